// File: doc/BRIEF.md
# Power-on reset and clock sequencer

This block brings a microcontroller out of reset in a fixed order once the board-level active-low reset input goes high. While that input is low, and for a settling interval after it goes high, the PLL is kept switched off so that the crystal oscillator can settle. When the settling count ends, the PLL is switched on and a second count covers its lock time. Only when that count ends does the block let go of the CPU reset. From then on the CPU runs in clock-through mode at one eighth of the oscillator rate.

Once the CPU is running, software uses a small write port to switch to PLL mode and to set the division ratio that the clock path outside this block applies to the PLL clock. The block accepts divider writes only while PLL mode is selected. All timing is counted in oscillator cycles. The analog oscillator, the PLL and the glitch-free clock multiplexer are outside this block. The block drives their control signals and gives a one-in-eight clock enable for clock-through operation.

Top module: `por_clk_seq`

## Requirements
- R1: While `ext_rst_n_i` is low, all outputs go at once, without waiting for a clock edge, to their idle values: `phase_o` = 0, `pll_en_o` = 0, `cpu_rst_n_o` = 0, `pll_mode_o` = 0, `cpu_div_o` = 0, `wait_cnt_o` = 0, `cpu_tick_o` = 0.
- R2: The release of `ext_rst_n_i` passes through a two-stage synchronizer. `phase_o` changes from 0 (reset) to 1 (oscillator wait) at the third rising edge of `osc_clk_i` after the release.
- R3: Phase 1 lasts exactly OSC_WAIT (8192) oscillator cycles, with `pll_en_o` held at 0. After that, `phase_o` becomes 2 (lock wait) and `pll_en_o` becomes 1.
- R4: Phase 2 lasts exactly LOCK_WAIT (8192) cycles, with `cpu_rst_n_o` held at 0. After that, `phase_o` becomes 3 (running) and `cpu_rst_n_o` becomes 1. Phase 3 is held until reset.
- R5: The 13-bit wait counter shown on `wait_cnt_o` is cleared to 0 when the lock count completes, and it stays at 0 while running.
- R6: If `ext_rst_n_i` goes low again in any phase, the sequencer returns to phase 0. After the next release, both timed phases run again in full.
- R7: While running in clock-through mode (`pll_mode_o` = 0), `cpu_tick_o` is high for exactly one cycle in every 8 oscillator cycles.
- R8: A write with `wr_addr_i` = 0 loads `pll_mode_o` from bit 0 of `wr_data_i` at the next edge. Such a write is accepted only in phase 3 and is ignored before then. When `pll_mode_o` = 1, PLL mode is selected and `cpu_tick_o` stays at 0.
- R9: A write with `wr_addr_i` = 1 loads `cpu_div_o` from bits 2:0 of `wr_data_i`. It is accepted only while `pll_mode_o` = 1; in clock-through mode `cpu_div_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Oscillator clock |
| ext_rst_n_i | input | 1 | External reset, active low, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Register select: 0 = mode, 1 = divider |
| wr_data_i | input | 8 | Write data |
| pll_en_o | output | 1 | PLL enable (0 = PLL stopped) |
| cpu_rst_n_o | output | 1 | Internal CPU reset, active low |
| pll_mode_o | output | 1 | Clock select: 1 = PLL, 0 = oscillator divided by 8 |
| cpu_div_o | output | 3 | CPU clock division code for the PLL path |
| cpu_tick_o | output | 1 | One-in-eight clock enable in clock-through mode |
| phase_o | output | 2 | 0 reset, 1 oscillator wait, 2 lock wait, 3 running |
| wait_cnt_o | output | 13 | Current interval count |

## Verification
The hardest situations to reach from the ports are a reset that comes back partway through the lock count, and a mode write that arrives during the lock count. Both depend on the stimulus acting inside a window that is thousands of cycles long. The bench polls `phase_o` on falling edges until the wanted phase shows, then changes `ext_rst_n_i` or issues a write just after that edge. The expected phase-change cycles are computed from the release cycle and queued, so every transition, including the return to phase 0 in the middle of a count, is compared at its exact cycle.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

    typedef enum logic [1:0] {
        PH_RESET     = 2'd0,
        PH_OSC_WAIT  = 2'd1,
        PH_LOCK_WAIT = 2'd2,
        PH_RUN       = 2'd3
    } phase_e;

    localparam logic ADDR_MODE = 1'b0;
    localparam logic ADDR_DIV  = 1'b1;

endpackage

// File: rtl/por_rst_sync.sv
module por_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic arst_n_i,
    output logic rel_o
);

    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sync_d = 1'b1;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
        end
    endgenerate

    always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) sync_q <= '0;
        else           sync_q <= sync_d;
    end

    assign rel_o = sync_q[STAGES-1];

endmodule

// File: rtl/por_phase_ctrl.sv
module por_phase_ctrl
    import por_seq_pkg::*;
#(
    parameter int OSC_WAIT  = 8192,
    parameter int LOCK_WAIT = 8192,
    parameter int CNT_W     = 13
) (
    input  logic             clk_i,
    input  logic             arst_n_i,
    input  logic             rel_i,
    output phase_e           phase_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pll_en_o,
    output logic             run_o
);

    localparam logic [CNT_W-1:0] OSC_LAST  = CNT_W'(OSC_WAIT - 1);
    localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_WAIT - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_RESET: begin
                st_d.cnt = '0;
                if (rel_i) st_d.phase = PH_OSC_WAIT;
            end
            PH_OSC_WAIT: begin
                if (st_q.cnt == OSC_LAST) begin
                    st_d.phase = PH_LOCK_WAIT;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_LOCK_WAIT: begin
                if (st_q.cnt == LOCK_LAST) begin
                    st_d.phase = PH_RUN;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            PH_RUN: st_d.cnt = '0;
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) begin
            st_q.phase <= PH_RESET;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o  = st_q.phase;
    assign cnt_o    = st_q.cnt;
    assign pll_en_o = (st_q.phase == PH_LOCK_WAIT) || (st_q.phase == PH_RUN);
    assign run_o    = (st_q.phase == PH_RUN);

    assert_osc_len_R3: assert property (@(posedge clk_i) disable iff (!arst_n_i)
        (st_q.phase == PH_OSC_WAIT && st_q.cnt == OSC_LAST) |=> (st_q.phase == PH_LOCK_WAIT));

    assert_lock_order_R4: assert property (@(posedge clk_i) disable iff (!arst_n_i)
        (st_q.phase == PH_LOCK_WAIT) |=> (st_q.phase == PH_LOCK_WAIT || st_q.phase == PH_RUN));

    assert_run_sticky_R4: assert property (@(posedge clk_i) disable iff (!arst_n_i)
        (st_q.phase == PH_RUN) |=> (st_q.phase == PH_RUN));

    assert_cnt_clear_R5: assert property (@(posedge clk_i) disable iff (!arst_n_i)
        (st_q.phase == PH_RUN) |-> (st_q.cnt == '0));

    assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!arst_n_i)
        (st_q.phase == PH_OSC_WAIT) |-> (st_q.cnt <= OSC_LAST));

endmodule

// File: rtl/por_clk_cfg.sv
module por_clk_cfg
    import por_seq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 3,
    parameter int CT_DIV = 8
) (
    input  logic              clk_i,
    input  logic              arst_n_i,
    input  logic              run_i,
    input  logic              wr_en_i,
    input  logic              wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              pll_mode_o,
    output logic [DIV_W-1:0]  div_o,
    output logic              tick_o
);

    localparam int                TICK_W    = (CT_DIV > 1) ? $clog2(CT_DIV) : 1;
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(CT_DIV - 1);

    typedef struct packed {
        logic              pll_mode;
        logic [DIV_W-1:0]  div;
        logic [TICK_W-1:0] tcnt;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run_i && wr_en_i) begin
            if (wr_addr_i == ADDR_MODE) begin
                st_d.pll_mode = wr_data_i[0];
            end else if (st_q.pll_mode) begin
                st_d.div = wr_data_i[DIV_W-1:0];
            end
        end
        if (run_i && !st_q.pll_mode) begin
            st_d.tcnt = (st_q.tcnt == TICK_LAST) ? '0 : st_q.tcnt + TICK_W'(1);
        end else begin
            st_d.tcnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) st_q <= '0;
        else           st_q <= st_d;
    end

    assign pll_mode_o = st_q.pll_mode;
    assign div_o      = st_q.div;
    assign tick_o     = run_i && !st_q.pll_mode && (st_q.tcnt == TICK_LAST);

    assert_div_frozen_R9: assert property (@(posedge clk_i) disable iff (!arst_n_i)
        (!st_q.pll_mode) |=> $stable(st_q.div));

    assert_mode_needs_run_R8: assert property (@(posedge clk_i) disable iff (!arst_n_i)
        (!run_i) |=> (!st_q.pll_mode));

    assert_tick_gap_R7: assert property (@(posedge clk_i) disable iff (!arst_n_i)
        tick_o |=> !tick_o);

endmodule

// File: rtl/por_clk_seq.sv
module por_clk_seq
    import por_seq_pkg::*;
#(
    parameter int OSC_WAIT    = 8192,
    parameter int LOCK_WAIT   = 8192,
    parameter int CNT_W       = 13,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 3,
    parameter int CT_DIV      = 8
) (
    input  logic              osc_clk_i,
    input  logic              ext_rst_n_i,
    input  logic              wr_en_i,
    input  logic              wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              pll_en_o,
    output logic              cpu_rst_n_o,
    output logic              pll_mode_o,
    output logic [DIV_W-1:0]  cpu_div_o,
    output logic              cpu_tick_o,
    output logic [1:0]        phase_o,
    output logic [CNT_W-1:0]  wait_cnt_o
);

    logic   rel;
    logic   run;
    phase_e phase;

    por_rst_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk_i    (osc_clk_i),
        .arst_n_i (ext_rst_n_i),
        .rel_o    (rel)
    );

    por_phase_ctrl #(
        .OSC_WAIT  (OSC_WAIT),
        .LOCK_WAIT (LOCK_WAIT),
        .CNT_W     (CNT_W)
    ) i_phase (
        .clk_i    (osc_clk_i),
        .arst_n_i (ext_rst_n_i),
        .rel_i    (rel),
        .phase_o  (phase),
        .cnt_o    (wait_cnt_o),
        .pll_en_o (pll_en_o),
        .run_o    (run)
    );

    por_clk_cfg #(
        .DATA_W (DATA_W),
        .DIV_W  (DIV_W),
        .CT_DIV (CT_DIV)
    ) i_cfg (
        .clk_i      (osc_clk_i),
        .arst_n_i   (ext_rst_n_i),
        .run_i      (run),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .pll_mode_o (pll_mode_o),
        .div_o      (cpu_div_o),
        .tick_o     (cpu_tick_o)
    );

    assign cpu_rst_n_o = run;
    assign phase_o     = phase;

    assert_rst_held_R4: assert property (@(posedge osc_clk_i) disable iff (!ext_rst_n_i)
        (!pll_en_o) |-> (!cpu_rst_n_o));

    assert_pll_stopped_R3: assert property (@(posedge osc_clk_i) disable iff (!ext_rst_n_i)
        (phase_o == 2'd1) |=> (phase_o != 2'd3));

endmodule

// File: tb/test_por_clk_seq.sv
module test_por_clk_seq;

    localparam int CLK_PERIOD = 10;
    localparam int OSC_WAIT   = 8192;
    localparam int LOCK_WAIT  = 8192;

    typedef struct {
        logic [1:0] phase;
        int         cyc;
    } exp_t;

    logic        clk = 1'b0;
    logic        ext_rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_addr = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        pll_en, cpu_rst_n, pll_mode, cpu_tick;
    logic [2:0]  cpu_div;
    logic [1:0]  phase;
    logic [12:0] wait_cnt;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t exp_q[$];
    logic [1:0] prev_phase = 2'd0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    por_clk_seq i_por_clk_seq (
        .osc_clk_i   (clk),
        .ext_rst_n_i (ext_rst_n),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .pll_en_o    (pll_en),
        .cpu_rst_n_o (cpu_rst_n),
        .pll_mode_o  (pll_mode),
        .cpu_div_o   (cpu_div),
        .cpu_tick_o  (cpu_tick),
        .phase_o     (phase),
        .wait_cnt_o  (wait_cnt)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compares each observed phase change with the queue head
    always @(negedge clk) begin
        if (phase !== prev_phase) begin
            string tag;
            exp_t  e;
            case (phase)
                2'd1: tag = "R2 phase->osc_wait";
                2'd2: tag = "R3 phase->lock_wait";
                2'd3: tag = "R4 phase->run";
                default: tag = "R6 phase->reset";
            endcase
            if (exp_q.size() == 0) begin
                chk({tag, " unexpected change"}, int'(phase), int'(prev_phase));
            end else begin
                e = exp_q.pop_front();
                chk({tag, " code"}, int'(phase), int'(e.phase));
                chk({tag, " cycle"}, cyc, e.cyc);
            end
            prev_phase = phase;
        end
    end

    // Driver: release reset and queue phase changes up to last_phase
    task automatic release_rst(input int last_phase);
        int base;
        exp_t e;
        @(negedge clk);
        #1 ext_rst_n = 1'b1;
        base = cyc;
        e.phase = 2'd1; e.cyc = base + 3;                       exp_q.push_back(e);
        if (last_phase >= 2) begin
            e.phase = 2'd2; e.cyc = base + 3 + OSC_WAIT;        exp_q.push_back(e);
        end
        if (last_phase >= 3) begin
            e.phase = 2'd3; e.cyc = base + 3 + OSC_WAIT + LOCK_WAIT; exp_q.push_back(e);
        end
    endtask

    task automatic abort_rst();
        exp_t e;
        @(negedge clk);
        #1 ext_rst_n = 1'b0;
        e.phase = 2'd0; e.cyc = cyc + 1; exp_q.push_back(e);
    endtask

    task automatic wait_phase(input logic [1:0] p);
        while (phase !== p) @(negedge clk);
    endtask

    task automatic wait_queue();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic reg_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic check_idle(input string req);
        chk({req, " pll_en"},    int'(pll_en), 0);
        chk({req, " cpu_rst_n"}, int'(cpu_rst_n), 0);
        chk({req, " pll_mode"},  int'(pll_mode), 0);
        chk({req, " cpu_div"},   int'(cpu_div), 0);
        chk({req, " wait_cnt"},  int'(wait_cnt), 0);
        chk({req, " cpu_tick"},  int'(cpu_tick), 0);
        chk({req, " phase"},     int'(phase), 0);
    endtask

    initial begin
        int ticks;
        repeat (3) @(negedge clk);
        check_idle("R1 reset state");

        // Full sequence, with a mode write attempted during lock wait
        release_rst(3);
        wait_phase(2'd1);
        repeat (100) @(negedge clk);
        chk("R3 pll held off in osc wait", int'(pll_en), 0);
        wait_phase(2'd2);
        chk("R3 pll enabled in lock wait", int'(pll_en), 1);
        reg_write(1'b0, 8'h01);
        chk("R8 mode write ignored before run", int'(pll_mode), 0);
        chk("R4 cpu reset held in lock wait", int'(cpu_rst_n), 0);
        wait_queue();
        repeat (2) @(negedge clk);
        chk("R4 cpu reset released", int'(cpu_rst_n), 1);
        chk("R5 wait counter cleared", int'(wait_cnt), 0);

        ticks = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (cpu_tick) ticks++;
        end
        chk("R7 ticks in 64 cycles", ticks, 8);

        reg_write(1'b1, 8'h05);
        chk("R9 div write ignored in clock-through", int'(cpu_div), 0);
        reg_write(1'b0, 8'h01);
        chk("R8 pll mode selected", int'(pll_mode), 1);
        ticks = 0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (cpu_tick) ticks++;
        end
        chk("R8 no tick in pll mode", ticks, 0);
        reg_write(1'b1, 8'h05);
        chk("R9 div accepted in pll mode", int'(cpu_div), 5);
        reg_write(1'b0, 8'h00);
        chk("R8 back to clock-through", int'(pll_mode), 0);
        reg_write(1'b1, 8'h02);
        chk("R9 div held in clock-through", int'(cpu_div), 5);
        chk("R5 wait counter stays zero", int'(wait_cnt), 0);

        // Reset asserted while running
        abort_rst();
        wait_queue();
        repeat (2) @(negedge clk);
        check_idle("R1 R6 reset from run");

        // Reset asserted during the oscillator wait
        release_rst(1);
        wait_queue();
        repeat (500) @(negedge clk);
        abort_rst();
        wait_queue();
        repeat (2) @(negedge clk);
        check_idle("R6 reset from osc wait");

        // Full sequence again, then reset during the lock wait
        release_rst(3);
        wait_queue();
        repeat (2) @(negedge clk);
        chk("R6 run after restart", int'(cpu_rst_n), 1);
        abort_rst();
        wait_queue();
        release_rst(2);
        wait_queue();
        repeat (1000) @(negedge clk);
        abort_rst();
        wait_queue();
        repeat (2) @(negedge clk);
        check_idle("R6 reset from lock wait");

        // Restart after a lock-wait abort must run both phases in full
        release_rst(3);
        wait_queue();
        repeat (2) @(negedge clk);
        chk("R4 run after lock abort", int'(phase), 3);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule